// File: doc/BRIEF.md
# Maskable Interrupt Aggregation Controller

This block gathers 32 interrupt sources into one output line for a parent interrupt controller. A rising edge on a source latches a bit in a pending register. That bit stays set until software acknowledges it. A second register, the mask, blocks individual sources. The output line is high whenever at least one pending bit is not blocked. Because it stays high for as long as such a bit remains, it behaves as a level interrupt.

Software reaches both registers over a plain 32-bit register bus with a write strobe, a read strobe, a byte address and data. Neither register is written directly. Each has its own write-one-to-set address and its own write-one-to-clear address, and the current value can be read back from every address that belongs to that register. Software can also raise a pending bit itself, which gives a software-triggered interrupt.

The reset state has every source blocked and nothing pending. The output line is a flop, so it reflects the pending and mask state one clock after that state changes.

Top module: `intagg_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has pending = 0x00000000, mask = 0xFFFFFFFF and `irq_o` = 0.
- R2: When `src_i[n]` is sampled high at an edge after being sampled low at the previous edge, pending bit n is 1 after that edge. The bit stays 1 after the source falls, until software clears it.
- R3: A write to offset 0x08 clears every pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R4: A write to offset 0x04 sets every pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R5: A write to offset 0x10 sets the mask bits whose data bit is 1, and a write to offset 0x14 clears them. Mask bits whose data bit is 0 keep their value. A mask bit of 1 blocks its source from `irq_o`.
- R6: `irq_o` is 1 exactly when, after the previous clock edge, (pending AND NOT mask) was non-zero. It therefore changes one clock after the register write or source edge that caused the change, and it stays high while an unmasked pending bit remains.
- R7: If a pending bit is set (by a source edge or an offset-0x04 write) and cleared by an offset-0x08 write at the same edge, the bit ends up 1.
- R8: With `bus_rd` high, offsets 0x00, 0x04 and 0x08 return the pending register, and offsets 0x0C, 0x10 and 0x14 return the mask register, both combinationally. With `bus_rd` low, `bus_rdata` is 0.
- R9: A read of any other offset, including unaligned ones, returns 0, and a write to such an offset changes neither register.
- R10: Writing 0xFFFFFFFF to offset 0x10 and then 0xFFFFFFFF to offset 0x08 leaves the mask all ones, the pending register all zeros, and `irq_o` low one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Interrupt source lines, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| irq_o | output | 1 | Registered interrupt line to the parent controller |

## Verification
The assertions check the following on every cycle:
- the reset values;
- that a pending bit only falls through an explicit clear;
- that a clear takes effect and that a simultaneous set beats it;
- that mask-set and mask-clear writes land;
- that a fully blocked mask keeps the output low;
- that unmapped reads return zero.

Only the bench scenarios can show the rest:
- the exact one-cycle lag of the output after a mask or pending change;
- that a level stays high across idle cycles;
- that pending survives a source that has dropped;
- that the alias addresses return the right register;
- that the mask-all-then-clear-all sequence leaves a quiet block.

// File: rtl/intagg_pkg.sv
package intagg_pkg;

    parameter int NSRC   = 32;
    parameter int ADDR_W = 8;

    typedef logic [NSRC-1:0]   vec_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Byte offsets seen by software; the map is fixed by the driver side.
    localparam addr_t OFF_PEND_STAT = ADDR_W'('h00);
    localparam addr_t OFF_PEND_SET  = ADDR_W'('h04);
    localparam addr_t OFF_PEND_CLR  = ADDR_W'('h08);
    localparam addr_t OFF_MASK_STAT = ADDR_W'('h0C);
    localparam addr_t OFF_MASK_SET  = ADDR_W'('h10);
    localparam addr_t OFF_MASK_CLR  = ADDR_W'('h14);

    typedef enum logic [2:0] {
        SEL_PEND_STAT,
        SEL_PEND_SET,
        SEL_PEND_CLR,
        SEL_MASK_STAT,
        SEL_MASK_SET,
        SEL_MASK_CLR,
        SEL_NONE
    } reg_sel_t;

    // Per-register update vectors produced by the decoder.
    typedef struct packed {
        vec_t pend_set;
        vec_t pend_clr;
        vec_t mask_set;
        vec_t mask_clr;
    } upd_t;

    function automatic reg_sel_t offset_to_sel(input addr_t a);
        case (a)
            OFF_PEND_STAT: return SEL_PEND_STAT;
            OFF_PEND_SET:  return SEL_PEND_SET;
            OFF_PEND_CLR:  return SEL_PEND_CLR;
            OFF_MASK_STAT: return SEL_MASK_STAT;
            OFF_MASK_SET:  return SEL_MASK_SET;
            OFF_MASK_CLR:  return SEL_MASK_CLR;
            default:       return SEL_NONE;
        endcase
    endfunction

    function automatic logic sel_is_pend(input reg_sel_t s);
        return (s == SEL_PEND_STAT) || (s == SEL_PEND_SET) || (s == SEL_PEND_CLR);
    endfunction

    function automatic logic sel_is_mask(input reg_sel_t s);
        return (s == SEL_MASK_STAT) || (s == SEL_MASK_SET) || (s == SEL_MASK_CLR);
    endfunction

endpackage

// File: rtl/intagg_decode.sv
module intagg_decode
    import intagg_pkg::*;
(
    input  logic     bus_wr,
    input  addr_t    bus_addr,
    input  vec_t     bus_wdata,
    output reg_sel_t sel,
    output upd_t     upd
);
    always_comb begin
        sel = offset_to_sel(bus_addr);
        upd = '0;
        if (bus_wr) begin
            case (sel)
                SEL_PEND_SET: upd.pend_set = bus_wdata;
                SEL_PEND_CLR: upd.pend_clr = bus_wdata;
                SEL_MASK_SET: upd.mask_set = bus_wdata;
                SEL_MASK_CLR: upd.mask_clr = bus_wdata;
                default:      upd = '0;
            endcase
        end
    end
endmodule

// File: rtl/intagg_edge.sv
module intagg_edge
    import intagg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  vec_t src_i,
    output vec_t rise
);
    vec_t src_q;

    // One stage of history per source; generate keeps each lane independent.
    for (genvar g = 0; g < NSRC; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) src_q[g] <= 1'b0;
            else     src_q[g] <= src_i[g];
        end
        assign rise[g] = src_i[g] & ~src_q[g];
    end
endmodule

// File: rtl/intagg_bank.sv
module intagg_bank
    import intagg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  upd_t upd,
    input  vec_t rise,
    output vec_t pend_q,
    output vec_t mask_q
);
    vec_t pend_d;
    vec_t mask_d;
    vec_t any_set;

    always_comb begin
        any_set = upd.pend_set | rise;
        // Set is ORed after the clear so a fresh event is never dropped.
        pend_d  = (pend_q & ~upd.pend_clr) | any_set;
        mask_d  = (mask_q & ~upd.mask_clr) | upd.mask_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '1;
        end else begin
            pend_q <= pend_d;
            mask_q <= mask_d;
        end
    end

    // R1: reset values
    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (pend_q == '0 && mask_q == '1));

    // R2: a pending bit drops only through an explicit clear
    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((pend_q & $past(pend_q & ~upd.pend_clr)) == $past(pend_q & ~upd.pend_clr)));

    // R3: cleared bits with no competing set end at zero
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (|upd.pend_clr) |=> ((pend_q & $past(upd.pend_clr & ~upd.pend_set & ~rise)) == '0));

    // R7: any set lands, even against a clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (|(upd.pend_set | rise)) |=>
            ((pend_q & $past(upd.pend_set | rise)) == $past(upd.pend_set | rise)));

    // R5: mask set and mask clear writes land
    p_mask_set_r5: assert property (@(posedge clk) disable iff (rst)
        (|upd.mask_set) |=> ((mask_q & $past(upd.mask_set)) == $past(upd.mask_set)));
    p_mask_clr_r5: assert property (@(posedge clk) disable iff (rst)
        (|upd.mask_clr) |=> ((mask_q & $past(upd.mask_clr)) == '0));
endmodule

// File: rtl/intagg_ctrl.sv
module intagg_ctrl
    import intagg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] src_i,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o
);
    reg_sel_t sel;
    upd_t     upd;
    vec_t     rise;
    vec_t     pend_q;
    vec_t     mask_q;
    logic     irq_q;

    intagg_decode u_decode (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sel       (sel),
        .upd       (upd)
    );

    intagg_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .src_i (src_i),
        .rise  (rise)
    );

    intagg_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .rise   (rise),
        .pend_q (pend_q),
        .mask_q (mask_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_is_pend(sel))      bus_rdata = pend_q;
            else if (sel_is_mask(sel)) bus_rdata = mask_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(pend_q & ~mask_q);
    end

    assign irq_o = irq_q;

    // R6: a fully blocked mask keeps the line low on the following cycle
    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |=> !irq_o);

    // R9: unmapped reads return zero
    p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_NONE) |-> (bus_rdata == '0));

    // R8: no read strobe means zero read data
    p_idle_rd_r8: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/sim_intagg_ctrl.sv
module sim_intagg_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    intagg_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge; the register updates at the next rising edge.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(8'h00, d); check("R1 pending after reset", d, 32'h0);
        bus_read(8'h0C, d); check("R1 mask after reset", d, 32'hFFFF_FFFF);
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_edge_latch();
        logic [31:0] d;
        src_i = 32'h0000_0005;
        cycles(1);
        bus_read(8'h00, d); check("R2 edge latched", d, 32'h0000_0005);
        src_i = '0;
        cycles(3);
        bus_read(8'h00, d); check("R2 pending sticky after source drop", d, 32'h0000_0005);
        check("R5 masked sources keep irq low", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        bus_write(8'h08, 32'h0000_0001);
        bus_read(8'h00, d); check("R3 write-one-to-clear", d, 32'h0000_0004);
    endtask

    task automatic t_set();
        logic [31:0] d;
        bus_write(8'h04, 32'h8000_0000);
        bus_read(8'h00, d); check("R4 write-one-to-set", d, 32'h8000_0004);
    endtask

    task automatic t_mask_irq();
        logic [31:0] d;
        bus_write(8'h14, 32'h0000_0004);
        bus_read(8'h0C, d); check("R5 mask clear", d, 32'hFFFF_FFFB);
        check("R6 irq lags mask change by one cycle", {31'b0, irq_o}, 32'h0);
        cycles(1);
        check("R6 irq rises", {31'b0, irq_o}, 32'h1);
        cycles(5);
        check("R6 irq level held", {31'b0, irq_o}, 32'h1);
        bus_write(8'h08, 32'h0000_0004);
        check("R6 irq lags pending clear", {31'b0, irq_o}, 32'h1);
        cycles(1);
        check("R6 irq falls after ack", {31'b0, irq_o}, 32'h0);
        bus_write(8'h10, 32'h0000_0004);
        bus_read(8'h0C, d); check("R5 mask set", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        bus_write(8'h04, 32'h0000_0008);
        src_i = 32'h0000_0008;
        bus_write(8'h08, 32'h0000_0008);
        bus_read(8'h00, d); check("R7 set beats clear", d, 32'h8000_0008);
        src_i = '0;
    endtask

    task automatic t_readback();
        logic [31:0] d;
        bus_read(8'h04, d); check("R8 pending at set offset", d, 32'h8000_0008);
        bus_read(8'h08, d); check("R8 pending at clear offset", d, 32'h8000_0008);
        bus_read(8'h10, d); check("R8 mask at set offset", d, 32'hFFFF_FFFF);
        bus_read(8'h14, d); check("R8 mask at clear offset", d, 32'hFFFF_FFFF);
        #1 check("R8 idle read data zero", bus_rdata, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_write(8'h09, 32'hFFFF_FFFF);
        bus_read(8'h00, d); check("R9 pending untouched", d, 32'h8000_0008);
        bus_read(8'h0C, d); check("R9 mask untouched", d, 32'hFFFF_FFFF);
        bus_read(8'h18, d); check("R9 unmapped read", d, 32'h0);
        bus_read(8'h02, d); check("R9 unaligned read", d, 32'h0);
    endtask

    task automatic t_quiesce();
        logic [31:0] d;
        bus_write(8'h14, 32'h8000_0000);
        cycles(1);
        check("R10 irq up before quiesce", {31'b0, irq_o}, 32'h1);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h00, d); check("R10 nothing pending", d, 32'h0);
        bus_read(8'h0C, d); check("R10 all masked", d, 32'hFFFF_FFFF);
        cycles(1);
        check("R10 irq low", {31'b0, irq_o}, 32'h0);
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(1);
        t_reset();
        t_edge_latch();
        t_clear();
        t_set();
        t_mask_irq();
        t_set_wins();
        t_readback();
        t_unmapped();
        t_quiesce();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule